// File: doc/BRIEF.md
# Four-Level Address Pin Decoder

This block derives a 7-bit two-wire-bus target address and two input-pullup enables from two address-select pins. Each pin may be strapped to ground, to the supply, to the bus data line or to the bus clock line, so each pin carries one of four values. The block does not read a level as a code. It compares each pin with the live data and clock lines and works out which of the four connections is present.

Both bus lines idle high. A pin strapped to a bus line therefore reads the same as a supply-tied pin until the bus moves. After reset, the block takes one snapshot of each pin once its synchronizers have settled. A pin that reads low is ground, and that result is final at once. A pin that reads high is first reported as supply-tied. The result is then revised after the first bus activity that gives enough evidence: one complete clock-high period and at least one data-line edge. The valid output shows that both pins are settled. The two pullup enables each serve one nibble of input ports. They follow the current classification at all times, so they are already correct for supply-only straps.

Top module: `addr_pin_decoder`

## Requirements
- R1: The three upper address bits, dev_addr[6:4], are always 3'b110.
- R2: dev_addr[3:0] equals {pin_b code, pin_a code}, where each code is 2'b00 for ground, 2'b01 for supply, 2'b10 for the data line and 2'b11 for the clock line.
- R3: pullup_lo is driven from the pin_a classification and pullup_hi from the pin_b classification. Each is 1 unless its pin is classified as ground.
- R4: While rst_n is low, both codes read as supply: dev_addr is 7'h65, both pullups are 1 and addr_valid is 0.
- R5: A pin that reads low at the post-reset snapshot is classified as ground at once. With both pins low, addr_valid rises with no bus activity at all.
- R6: A pin that reads high at the snapshot is reported as supply, and addr_valid stays low, until an SCL rise followed by an SCL fall and at least one SDA edge have both been seen. Data-line edges alone do not end the observation.
- R7: When observation ends, a pin that never read low becomes supply. Otherwise it becomes data-line if it matched SDA on every sample, else clock-line if it matched SCL on every sample, else ground.
- R8: addr_valid is high exactly when both pins are classified. Once high, it and the address stay fixed until reset, whatever happens on the pins or the bus.
- R9: Pins and bus lines pass through the same two-stage synchronizer before any comparison. addr_valid therefore stays low for the first two clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_a | input | 1 | First address-select pin (asynchronous) |
| pin_b | input | 1 | Second address-select pin (asynchronous) |
| sda_in | input | 1 | Bus data line as seen at the pad (asynchronous) |
| scl_in | input | 1 | Bus clock line as seen at the pad (asynchronous) |
| dev_addr | output | 7 | Decoded target address |
| addr_valid | output | 1 | Both pins classified; address final |
| pullup_lo | output | 1 | Pullup enable for input ports 0 to 3 |
| pullup_hi | output | 1 | Pullup enable for input ports 4 to 7 |

## Verification
The hardest case to reach is telling a pin tied to the data line apart from one tied to the clock line. Both read high until a transfer starts, and they separate only at the start condition, where the data line falls while the clock line is held high. The bench models each strap as a continuous connection to its own bus-line variables. It then drives real transfers: start, clocked bits and stop. It also drives a start-then-stop with no clock pulse, to show that data-line edges alone leave the result unresolved.

// File: rtl/adp_pkg.sv
// Package: shared types for the address pin decoder.
// Assumes: the code values are part of the address encoding and must not change.
package adp_pkg;

    // Strap connection of one address-select pin; value is its address code.
    typedef enum logic [1:0] {
        CONN_GND = 2'b00,
        CONN_VDD = 2'b01,
        CONN_SDA = 2'b10,
        CONN_SCL = 2'b11
    } conn_e;

    // Per-pin classification phase.
    typedef enum logic [1:0] {
        PH_SETTLE  = 2'b00,
        PH_OBSERVE = 2'b01,
        PH_DONE    = 2'b10
    } phase_e;

endpackage

// File: rtl/adp_sync.sv
// Module: adp_sync
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: all bits share the same depth, so their relative timing is preserved.
// Every stage resets high, which matches idle bus lines.
module adp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/adp_bus_monitor.sv
// Module: adp_bus_monitor
// Finds edges on the synchronized bus lines, for use by the pin classifiers.
// Assumes: its inputs are already synchronized. Its outputs are one-cycle pulses
// that line up with the current synchronized sample.
module adp_bus_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_edge
);
    logic sda_q;
    logic scl_q;

    // Keep the previous sample of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_s;
            scl_q <= scl_s;
        end
    end

    // Edge pulses from the current and previous samples.
    always_comb begin
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        sda_edge = sda_s ^ sda_q;
    end
endmodule

// File: rtl/adp_pin_classifier.sv
// Module: adp_pin_classifier
// Works out what one address-select pin is strapped to.
// Flow: wait SETTLE_CYC clocks, snapshot the pin (low = ground, final), then
// gather evidence against the bus until one full SCL high period and one
// SDA edge are seen, then decide. The result holds until reset.
// Assumes: pin, sda and scl come through one common synchronizer.
module adp_pin_classifier
    import adp_pkg::*;
#(
    parameter int SETTLE_CYC = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_s,
    input  logic  sda_s,
    input  logic  scl_s,
    input  logic  scl_rise,
    input  logic  scl_fall,
    input  logic  sda_edge,
    output conn_e code,
    output logic  final_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

    phase_e      phase;
    logic [CW-1:0] cnt;
    logic        low_seen, mis_sda, mis_scl, rise_seen, period_done, sdae_seen;
    logic        low_n, mis_sda_n, mis_scl_n, rise_n, period_n, sdae_n;
    conn_e       verdict;

    // Fold the current sample into the evidence gathered so far.
    always_comb begin
        low_n     = low_seen | ~pin_s;
        mis_sda_n = mis_sda | (pin_s ^ sda_s);
        mis_scl_n = mis_scl | (pin_s ^ scl_s);
        rise_n    = rise_seen | scl_rise;
        period_n  = period_done | (rise_seen & scl_fall);
        sdae_n    = sdae_seen | sda_edge;
    end

    // Decide the connection from the evidence, data line first.
    always_comb begin
        if (!low_n)          verdict = CONN_VDD;
        else if (!mis_sda_n) verdict = CONN_SDA;
        else if (!mis_scl_n) verdict = CONN_SCL;
        else                 verdict = CONN_GND;
    end

    // Phase sequencing, evidence registers and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_SETTLE;
            cnt         <= '0;
            code        <= CONN_VDD;
            final_o     <= 1'b0;
            low_seen    <= 1'b0;
            mis_sda     <= 1'b0;
            mis_scl     <= 1'b0;
            rise_seen   <= 1'b0;
            period_done <= 1'b0;
            sdae_seen   <= 1'b0;
        end else begin
            case (phase)
                PH_SETTLE: begin
                    if (cnt == CNT_LAST) begin
                        if (!pin_s) begin
                            code    <= CONN_GND;
                            final_o <= 1'b1;
                            phase   <= PH_DONE;
                        end else begin
                            code  <= CONN_VDD;
                            phase <= PH_OBSERVE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_OBSERVE: begin
                    low_seen    <= low_n;
                    mis_sda     <= mis_sda_n;
                    mis_scl     <= mis_scl_n;
                    rise_seen   <= rise_n;
                    period_done <= period_n;
                    sdae_seen   <= sdae_n;
                    if (period_n && sdae_n) begin
                        code    <= verdict;
                        final_o <= 1'b1;
                        phase   <= PH_DONE;
                    end
                end
                default: begin
                    phase <= PH_DONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/addr_pin_decoder.sv
// Module: addr_pin_decoder (top)
// Decodes two four-level address-select pins into a 7-bit target address,
// a valid flag and two nibble pullup enables.
// Assumes: all inputs are asynchronous. Reset is synchronous and active low.
module addr_pin_decoder
    import adp_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         SETTLE_CYC  = 3,
    parameter logic [2:0] ADDR_HI     = 3'b110
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_a,
    input  logic       pin_b,
    input  logic       sda_in,
    input  logic       scl_in,
    output logic [6:0] dev_addr,
    output logic       addr_valid,
    output logic       pullup_lo,
    output logic       pullup_hi
);
    localparam int NPIN = 2;
    localparam int SW   = NPIN + 2;

    logic [SW-1:0]   raw_v, sync_v;
    logic [NPIN-1:0] pin_s;
    logic            sda_s, scl_s;
    logic            scl_rise, scl_fall, sda_edge;
    conn_e           code [NPIN];
    logic [NPIN-1:0] fin;
    logic [NPIN-1:0] pu;

    assign raw_v = {scl_in, sda_in, pin_b, pin_a};

    adp_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_v),
        .d_out (sync_v)
    );

    assign pin_s = sync_v[NPIN-1:0];
    assign sda_s = sync_v[NPIN];
    assign scl_s = sync_v[NPIN+1];

    adp_bus_monitor u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_s    (scl_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_edge (sda_edge)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        adp_pin_classifier #(.SETTLE_CYC(SETTLE_CYC)) u_cls (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_s    (pin_s[g]),
            .sda_s    (sda_s),
            .scl_s    (scl_s),
            .scl_rise (scl_rise),
            .scl_fall (scl_fall),
            .sda_edge (sda_edge),
            .code     (code[g]),
            .final_o  (fin[g])
        );
        assign pu[g] = (code[g] != CONN_GND);
    end

    // Assemble the outputs from the per-pin results.
    always_comb begin
        dev_addr   = {ADDR_HI, code[1], code[0]};
        addr_valid = &fin;
        pullup_lo  = pu[0];
        pullup_hi  = pu[1];
    end
endmodule

// File: rtl/addr_pin_decoder_sva.sv
// Module: addr_pin_decoder_sva
// Checker for addr_pin_decoder, attached with bind. It watches ports only.
// Assumes: SETTLE_CYC matches the bound instance.
module addr_pin_decoder_sva #(
    parameter int SETTLE_CYC = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] dev_addr,
    input logic       addr_valid,
    input logic       pullup_lo,
    input logic       pullup_hi
);
    localparam int CW = $clog2(SETTLE_CYC + 2);
    logic [CW-1:0] since_rst;

    // Count the cycles since reset was released, saturating at SETTLE_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst < CW'(SETTLE_CYC)) since_rst <= since_rst + 1'b1;
    end

    assert_upper_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dev_addr[6:4] == 3'b110);

    assert_pullup_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pullup_lo == (dev_addr[1:0] != 2'b00)) && (pullup_hi == (dev_addr[3:2] != 2'b00)));

    assert_guess_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (dev_addr[1] == 1'b0 && dev_addr[3] == 1'b0));

    assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> addr_valid);

    assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> $stable(dev_addr));

    assert_settle_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(SETTLE_CYC)) |-> !addr_valid);
endmodule

bind addr_pin_decoder addr_pin_decoder_sva #(.SETTLE_CYC(SETTLE_CYC)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_addr   (dev_addr),
    .addr_valid (addr_valid),
    .pullup_lo  (pullup_lo),
    .pullup_hi  (pullup_hi)
);

// File: tb/addr_pin_decoder_tb.sv
module addr_pin_decoder_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda = 1'b1, scl = 1'b1;
    logic [1:0] conn_a = 2'b01, conn_b = 2'b01;   // 0 gnd, 1 supply, 2 data, 3 clock
    logic pin_a, pin_b;
    logic [6:0] dev_addr;
    logic addr_valid, pullup_lo, pullup_hi;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Strap model: each pin is tied to the chosen net.
    assign pin_a = (conn_a == 2'd0) ? 1'b0 : (conn_a == 2'd1) ? 1'b1 : (conn_a == 2'd2) ? sda : scl;
    assign pin_b = (conn_b == 2'd0) ? 1'b0 : (conn_b == 2'd1) ? 1'b1 : (conn_b == 2'd2) ? sda : scl;

    addr_pin_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .sda_in(sda), .scl_in(scl), .dev_addr(dev_addr),
        .addr_valid(addr_valid), .pullup_lo(pullup_lo), .pullup_hi(pullup_hi)
    );

    task automatic chk(input string req, input logic [6:0] ea, input logic ev,
                       input logic elo, input logic ehi);
        checks++;
        if (dev_addr !== ea || addr_valid !== ev || pullup_lo !== elo || pullup_hi !== ehi) begin
            fails++;
            $display("FAIL %s: got addr=%h valid=%b lo=%b hi=%b, expected addr=%h valid=%b lo=%b hi=%b",
                     req, dev_addr, addr_valid, pullup_lo, pullup_hi, ea, ev, elo, ehi);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset with the given straps and idle bus, then release and let it settle.
    task automatic restart(input logic [1:0] a, input logic [1:0] b);
        @(negedge clk);
        rst_n = 1'b0; conn_a = a; conn_b = b; sda = 1'b1; scl = 1'b1;
        step(4);
        rst_n = 1'b1;
        step(10);
    endtask

    // One bus transfer: start, a few clocked bits, stop.
    task automatic transfer(input logic [3:0] bits);
        sda = 1'b0; step(4);
        scl = 1'b0; step(4);
        for (int i = 3; i >= 0; i--) begin
            sda = bits[i]; step(4);
            scl = 1'b1; step(4);
            scl = 1'b0; step(4);
        end
        sda = 1'b0; step(4);
        scl = 1'b1; step(4);
        sda = 1'b1; step(6);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0; conn_a = 2'd0; conn_b = 2'd0;
        step(4);
        chk("R4 reset state", 7'h65, 1'b0, 1'b1, 1'b1);
        rst_n = 1'b1;
        step(1);
        chk("R9 no valid right after release", 7'h65, 1'b0, 1'b1, 1'b1);
        step(10);
        chk("R5 gnd/gnd valid without bus", 7'h60, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_supply_pair();
        restart(2'd1, 2'd1);
        chk("R6 supply pair waits for bus", 7'h65, 1'b0, 1'b1, 1'b1);
        transfer(4'b1010);
        chk("R7 supply pair resolves to supply", 7'h65, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_sda_scl();
        restart(2'd2, 2'd3);
        chk("R6 bus straps guessed as supply", 7'h65, 1'b0, 1'b1, 1'b1);
        transfer(4'b0110);
        chk("R2 data/clock straps encode 1110", 7'h6E, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_gnd_sda();
        restart(2'd0, 2'd2);
        chk("R3 gnd low nibble pullup off before bus", 7'h64, 1'b0, 1'b0, 1'b1);
        transfer(4'b1001);
        chk("R2 gnd/data encodes 1000", 7'h68, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_scl_vdd();
        restart(2'd3, 2'd1);
        transfer(4'b1100);
        chk("R7 clock/supply encodes 0111", 7'h67, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_partial_activity();
        restart(2'd2, 2'd0);
        sda = 1'b0; step(6);
        sda = 1'b1; step(6);
        chk("R6 data edges alone leave pin unresolved", 7'h61, 1'b0, 1'b1, 1'b0);
        transfer(4'b0101);
        chk("R7 data/gnd after full transfer", 7'h62, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_hold_after_final();
        restart(2'd3, 2'd2);
        transfer(4'b0011);
        chk("R2 clock/data encodes 1011", 7'h6B, 1'b1, 1'b1, 1'b1);
        conn_a = 2'd0; conn_b = 2'd0;
        step(6);
        transfer(4'b1111);
        chk("R8 result holds after strap change", 7'h6B, 1'b1, 1'b1, 1'b1);
        chk("R1 upper bits fixed", {3'b110, dev_addr[3:0]}, 1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_supply_pair();
        t_sda_scl();
        t_gnd_sda();
        t_scl_vdd();
        t_partial_activity();
        t_hold_after_final();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule